// File: doc/BRIEF.md
# Manchester Serial Word Receiver

This block recovers 16-bit words from a 1 Mbit/s half-duplex Manchester line of the command/response avionics kind. The line reaches it already turned into one logic-level input. The system clock samples that input 16 times per bit period. Each level change on the line is a possible start of a word. At that change the block measures how long the old level lasted. If the old level lasted for one and a half bit times, the block treats it as the first half of a synchronization header. The level of that first half gives the word type: a low first half means a command word and a high first half means a data word.

After the header, the block reads each bit by sampling the middle of both halves. It shifts in 16 data bits, most significant first, and then one parity bit. A word whose parity is correct raises a one-cycle valid strobe. The word and its type are held on the outputs until the next good word arrives. A bad parity bit or a bit with no mid-bit change raises a one-cycle error strobe instead. The block then goes back to hunting for a header.

Top module: `mrx_word_receiver`

## Requirements
- R1: While reset is high and in the first cycle after it, `word_o` and `cmd_o` are 0 and `valid_o` and `err_o` are low.
- R2: A bit whose first half is high and second half low decodes as 1. A bit whose first half is low and second half high decodes as 0. The first data bit after the header lands in `word_o[15]` and the sixteenth in `word_o[0]`.
- R3: A header whose first phase is low gives `cmd_o` = 1 (command word). A header whose first phase is high gives `cmd_o` = 0 (data word).
- R4: A header first phase is accepted only when its length, measured between two line transitions, is 20 to 28 samples. A phase of 19 or 29 samples produces no strobe of either kind.
- R5: The second header phase must still be at the opposite level at its middle sample. Otherwise the candidate is dropped with no strobe.
- R6: After a valid header, 17 bits are read: 16 data bits and a parity bit. When the count of ones over all 17 bits is odd, `valid_o` pulses for exactly one cycle with the word on `word_o`.
- R7: When the count of ones over the 17 bits is even, `err_o` pulses for one cycle and `valid_o` stays low.
- R8: A bit whose two halves are at the same level aborts the word. `err_o` pulses once and `valid_o` stays low. This applies to any of the 17 bits, the parity bit included.
- R9: `word_o` and `cmd_o` change only in a cycle where `valid_o` is high. Rejected or failed words leave them unchanged.
- R10: `valid_o` and `err_o` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock, 16 times the line bit rate |
| rst | input | 1 | Synchronous active-high reset |
| rx_line | input | 1 | Logic-level Manchester line, asynchronous to clk |
| word_o | output | 16 | Last good word received, MSB first on the line |
| cmd_o | output | 1 | Type of the last good word: 1 = command, 0 = data |
| valid_o | output | 1 | One-cycle strobe when a word passes parity |
| err_o | output | 1 | One-cycle strobe on a parity failure or a Manchester violation |

## Verification
The checker covers the properties that hold on every cycle:
- the two strobes never overlap and each lasts one cycle;
- the output word and type never move without a valid strobe;
- reset leaves the outputs quiet.

Only the bench scenarios can show the behaviour that depends on timing:
- which header lengths are accepted and which rejected;
- that header polarity sets the word type;
- the bit order and the decoded values;
- that a broken second header phase, a bad parity bit and a violation at the first bit, a middle bit or the parity bit each end in the right strobe or in silence.

// File: rtl/mrx_pkg.sv
package mrx_pkg;

    // Word type carried by the header polarity
    typedef enum logic {
        KIND_DATA = 1'b0,
        KIND_CMD  = 1'b1
    } word_kind_e;

    // Header hunter states
    typedef enum logic {
        HS_HUNT    = 1'b0,
        HS_CONFIRM = 1'b1
    } hunt_state_e;

    // Bit slicer states
    typedef enum logic {
        BS_IDLE = 1'b0,
        BS_BITS = 1'b1
    } slice_state_e;

    // First-phase level decides the word type: low marks a command
    function automatic word_kind_e kind_from_level(input logic first_level);
        return first_level ? KIND_DATA : KIND_CMD;
    endfunction

    // Both halves equal means no mid-bit transition
    function automatic logic is_violation(input logic half_a, input logic half_b);
        return half_a == half_b;
    endfunction

endpackage

// File: rtl/mrx_line_front.sv
module mrx_line_front #(
    parameter int RUN_LIMIT = 29,
    parameter int RUN_W     = $clog2(RUN_LIMIT + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             rx_i,
    output logic             line_o,
    output logic             edge_o,
    output logic             prev_o,
    output logic [RUN_W-1:0] run_o
);

    localparam logic [RUN_W-1:0] RUN_MAX = RUN_W'(RUN_LIMIT);
    localparam logic [RUN_W-1:0] RUN_ONE = RUN_W'(1);

    logic meta_q;
    logic line_q;
    logic line_d;
    logic [RUN_W-1:0] run_q;

    // Two-stage synchronizer plus one delay stage for edge detection
    always_ff @(posedge clk) begin
        if (rst) begin
            meta_q <= 1'b0;
            line_q <= 1'b0;
            line_d <= 1'b0;
        end else begin
            meta_q <= rx_i;
            line_q <= meta_q;
            line_d <= line_q;
        end
    end

    // Length of the current level run, saturating so reset looks like a long idle
    always_ff @(posedge clk) begin
        if (rst) begin
            run_q <= RUN_MAX;
        end else if (line_q != line_d) begin
            run_q <= RUN_ONE;
        end else if (run_q != RUN_MAX) begin
            run_q <= run_q + RUN_ONE;
        end
    end

    assign line_o = line_q;
    assign edge_o = line_q ^ line_d;
    assign prev_o = line_d;
    assign run_o  = run_q;

endmodule

// File: rtl/mrx_sync_hunter.sv
module mrx_sync_hunter
    import mrx_pkg::*;
#(
    parameter int SYNC_MIN = 20,
    parameter int SYNC_MAX = 28,
    parameter int SYNC_LEN = 24,
    parameter int RUN_W    = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             enable_i,
    input  logic             line_i,
    input  logic             edge_i,
    input  logic             prev_i,
    input  logic [RUN_W-1:0] run_i,
    output logic             start_o,
    output word_kind_e       kind_o
);

    localparam int CW = $clog2(SYNC_LEN);
    localparam logic [CW-1:0]    MID_CNT = CW'(SYNC_LEN / 2 - 1);
    localparam logic [CW-1:0]    END_CNT = CW'(SYNC_LEN - 2);
    localparam logic [RUN_W-1:0] LEN_LO  = RUN_W'(SYNC_MIN);
    localparam logic [RUN_W-1:0] LEN_HI  = RUN_W'(SYNC_MAX);

    hunt_state_e state_q;
    logic [CW-1:0] cnt_q;
    logic          expect_q;
    logic          start_q;
    word_kind_e    kind_q;
    logic          first_ok;

    // A transition closes a candidate first phase; its length decides acceptance
    assign first_ok = edge_i && (run_i >= LEN_LO) && (run_i <= LEN_HI);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= HS_HUNT;
            cnt_q    <= '0;
            expect_q <= 1'b0;
            start_q  <= 1'b0;
            kind_q   <= KIND_DATA;
        end else begin
            start_q <= 1'b0;
            unique case (state_q)
                HS_HUNT: begin
                    if (enable_i && first_ok) begin
                        state_q  <= HS_CONFIRM;
                        cnt_q    <= '0;
                        expect_q <= line_i;
                        kind_q   <= kind_from_level(prev_i);
                    end
                end
                HS_CONFIRM: begin
                    cnt_q <= cnt_q + CW'(1);
                    if (cnt_q == MID_CNT && line_i != expect_q) begin
                        state_q <= HS_HUNT;
                    end else if (cnt_q == END_CNT) begin
                        state_q <= HS_HUNT;
                        start_q <= 1'b1;
                    end
                end
                default: state_q <= HS_HUNT;
            endcase
        end
    end

    assign start_o = start_q;
    assign kind_o  = kind_q;

endmodule

// File: rtl/mrx_bit_slicer.sv
module mrx_bit_slicer
    import mrx_pkg::*;
#(
    parameter int WORD_W = 16,
    parameter int SPB    = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              line_i,
    input  logic              start_i,
    input  word_kind_e        kind_i,
    output logic              busy_o,
    output logic              done_o,
    output logic              fail_o,
    output logic [WORD_W-1:0] word_o,
    output word_kind_e        kind_o
);

    localparam int PW   = $clog2(SPB);
    localparam int BW   = $clog2(WORD_W + 1);
    localparam int SH_W = WORD_W + 1;
    localparam logic [PW-1:0] SAMPLE_A = PW'(SPB / 4);
    localparam logic [PW-1:0] SAMPLE_B = PW'(3 * SPB / 4);
    localparam logic [BW-1:0] LAST_BIT = BW'(WORD_W);

    slice_state_e    state_q;
    logic [PW-1:0]   phase_q;
    logic [BW-1:0]   bit_q;
    logic            half_a_q;
    logic [SH_W-1:0] shift_q;
    logic [SH_W-1:0] shift_nxt;
    logic            done_q;
    logic            fail_q;
    word_kind_e      kind_q;

    // The first half level is the bit value
    assign shift_nxt = {shift_q[SH_W-2:0], half_a_q};

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= BS_IDLE;
            phase_q  <= '0;
            bit_q    <= '0;
            half_a_q <= 1'b0;
            shift_q  <= '0;
            done_q   <= 1'b0;
            fail_q   <= 1'b0;
            kind_q   <= KIND_DATA;
        end else begin
            done_q <= 1'b0;
            fail_q <= 1'b0;
            if (start_i) begin
                state_q <= BS_BITS;
                phase_q <= PW'(1);
                bit_q   <= '0;
                kind_q  <= kind_i;
            end else if (state_q == BS_BITS) begin
                phase_q <= phase_q + PW'(1);
                if (phase_q == SAMPLE_A) begin
                    half_a_q <= line_i;
                end else if (phase_q == SAMPLE_B) begin
                    if (is_violation(half_a_q, line_i)) begin
                        fail_q  <= 1'b1;
                        state_q <= BS_IDLE;
                    end else begin
                        shift_q <= shift_nxt;
                        if (bit_q == LAST_BIT) begin
                            state_q <= BS_IDLE;
                            if (^shift_nxt) begin
                                done_q <= 1'b1;
                            end else begin
                                fail_q <= 1'b1;
                            end
                        end else begin
                            bit_q <= bit_q + BW'(1);
                        end
                    end
                end
            end
        end
    end

    assign busy_o = (state_q == BS_BITS);
    assign done_o = done_q;
    assign fail_o = fail_q;
    assign word_o = shift_q[SH_W-1:1];
    assign kind_o = kind_q;

endmodule

// File: rtl/mrx_word_receiver.sv
module mrx_word_receiver
    import mrx_pkg::*;
#(
    parameter int WORD_W   = 16,
    parameter int SPB      = 16,
    parameter int SYNC_MIN = 20,
    parameter int SYNC_MAX = 28
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rx_line,
    output logic [WORD_W-1:0] word_o,
    output logic              cmd_o,
    output logic              valid_o,
    output logic              err_o
);

    localparam int SYNC_LEN  = 3 * SPB / 2;
    localparam int RUN_LIMIT = SYNC_MAX + 1;
    localparam int RUN_W     = $clog2(RUN_LIMIT + 1);

    logic             line_s;
    logic             edge_s;
    logic             prev_s;
    logic [RUN_W-1:0] run_s;
    logic             start_s;
    word_kind_e       hunt_kind;
    logic             busy_s;
    logic             done_s;
    logic             fail_s;
    logic [WORD_W-1:0] slice_word;
    word_kind_e       slice_kind;

    logic [WORD_W-1:0] word_q;
    word_kind_e       kind_q;
    logic             valid_q;
    logic             err_q;

    mrx_line_front #(
        .RUN_LIMIT(RUN_LIMIT),
        .RUN_W    (RUN_W)
    ) u_front (
        .clk   (clk),
        .rst   (rst),
        .rx_i  (rx_line),
        .line_o(line_s),
        .edge_o(edge_s),
        .prev_o(prev_s),
        .run_o (run_s)
    );

    mrx_sync_hunter #(
        .SYNC_MIN(SYNC_MIN),
        .SYNC_MAX(SYNC_MAX),
        .SYNC_LEN(SYNC_LEN),
        .RUN_W   (RUN_W)
    ) u_hunter (
        .clk     (clk),
        .rst     (rst),
        .enable_i(!busy_s && !start_s),
        .line_i  (line_s),
        .edge_i  (edge_s),
        .prev_i  (prev_s),
        .run_i   (run_s),
        .start_o (start_s),
        .kind_o  (hunt_kind)
    );

    mrx_bit_slicer #(
        .WORD_W(WORD_W),
        .SPB   (SPB)
    ) u_slicer (
        .clk    (clk),
        .rst    (rst),
        .line_i (line_s),
        .start_i(start_s),
        .kind_i (hunt_kind),
        .busy_o (busy_s),
        .done_o (done_s),
        .fail_o (fail_s),
        .word_o (slice_word),
        .kind_o (slice_kind)
    );

    // Output holding register: loads only on a good word
    always_ff @(posedge clk) begin
        if (rst) begin
            word_q  <= '0;
            kind_q  <= KIND_DATA;
            valid_q <= 1'b0;
            err_q   <= 1'b0;
        end else begin
            valid_q <= done_s;
            err_q   <= fail_s;
            if (done_s) begin
                word_q <= slice_word;
                kind_q <= slice_kind;
            end
        end
    end

    assign word_o  = word_q;
    assign cmd_o   = (kind_q == KIND_CMD);
    assign valid_o = valid_q;
    assign err_o   = err_q;

endmodule

// File: rtl/mrx_word_receiver_chk.sv
module mrx_word_receiver_chk #(
    parameter int WORD_W = 16
) (
    input logic              clk,
    input logic              rst,
    input logic [WORD_W-1:0] word_o,
    input logic              cmd_o,
    input logic              valid_o,
    input logic              err_o
);

    AST_RESET_QUIET: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!valid_o && !err_o && word_o == '0 && !cmd_o)); // R1

    AST_VALID_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        valid_o |=> !valid_o); // R6

    AST_ERR_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        err_o |=> !err_o); // R7

    AST_WORD_HELD: assert property (@(posedge clk) disable iff (rst)
        !valid_o |-> ($stable(word_o) && $stable(cmd_o))); // R9

    AST_STROBE_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
        !(valid_o && err_o)); // R10

endmodule

bind mrx_word_receiver mrx_word_receiver_chk #(
    .WORD_W(WORD_W)
) u_chk (
    .clk    (clk),
    .rst    (rst),
    .word_o (word_o),
    .cmd_o  (cmd_o),
    .valid_o(valid_o),
    .err_o  (err_o)
);

// File: tb/mrx_word_receiver_tb.sv
`timescale 1ns/1ps
module mrx_word_receiver_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        rx_line = 1'b1;
    logic [15:0] word_o;
    logic        cmd_o;
    logic        valid_o;
    logic        err_o;

    int n_checks = 0;
    int n_errors = 0;
    int n_valid  = 0;
    int n_err    = 0;
    int n_both   = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    mrx_word_receiver u_dut (
        .clk    (clk),
        .rst    (rst),
        .rx_line(rx_line),
        .word_o (word_o),
        .cmd_o  (cmd_o),
        .valid_o(valid_o),
        .err_o  (err_o)
    );

    // Strobe monitor, sampled on the falling edge
    always @(negedge clk) begin
        if (!rst) begin
            if (valid_o) n_valid++;
            if (err_o) n_err++;
            if (valid_o && err_o) n_both++;
        end
    end

    // Vector fields: [27] command, [26:11] data, [10] bad parity,
    // [9:5] first header phase length, [4:0] violation bit index (31 = none)
    localparam int NV = 10;
    localparam logic [27:0] VEC [NV] = '{
        {1'b1, 16'hA5C3, 1'b0, 5'd24, 5'd31},
        {1'b0, 16'h0000, 1'b0, 5'd24, 5'd31},
        {1'b0, 16'hFFFF, 1'b0, 5'd20, 5'd31},
        {1'b1, 16'h8001, 1'b0, 5'd28, 5'd31},
        {1'b1, 16'h1234, 1'b1, 5'd24, 5'd31},
        {1'b0, 16'h00FF, 1'b0, 5'd24, 5'd5},
        {1'b1, 16'h5555, 1'b0, 5'd19, 5'd31},
        {1'b0, 16'h3C3C, 1'b0, 5'd29, 5'd31},
        {1'b0, 16'h7E81, 1'b0, 5'd24, 5'd0},
        {1'b1, 16'hFFFE, 1'b0, 5'd24, 5'd16}
    };

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic put(input logic lv, input int n);
        repeat (n) begin
            @(negedge clk);
            rx_line = lv;
        end
    endtask

    // Build one word on the line at 16 samples per bit
    task automatic send(input logic cmd, input logic [15:0] data, input logic bad,
                        input int flen, input int viol);
        logic lv;
        logic prev;
        logic b;
        logic par;
        lv  = cmd ? 1'b0 : 1'b1;
        par = ~(^data) ^ bad;
        put(~lv, 40);
        put(lv, flen);
        if (flen < 20 || flen > 28) begin
            put(~lv, 40);
            return;
        end
        put(~lv, 24);
        prev = ~lv;
        for (int i = 0; i < 17; i++) begin
            b = (i < 16) ? data[15 - i] : par;
            if (i == viol) begin
                put(~prev, 16);
                put(prev, 40);
                return;
            end
            put(b, 8);
            put(~b, 8);
            prev = ~b;
        end
        put(prev, 40);
    endtask

    initial begin
        logic [15:0] last_word;
        logic        last_cmd;
        int v0;
        int e0;
        last_word = '0;
        last_cmd  = 1'b0;

        repeat (4) @(negedge clk);
        check(word_o == 16'h0 && cmd_o == 1'b0 && !valid_o && !err_o, "R1 reset",
              {14'h0, valid_o, err_o, word_o}, 32'h0);
        @(negedge clk);
        rst = 1'b0;
        check(!valid_o && !err_o && word_o == 16'h0, "R1 after release",
              {14'h0, valid_o, err_o, word_o}, 32'h0);
        put(1'b1, 50);

        for (int k = 0; k < NV; k++) begin
            logic        cmd;
            logic [15:0] data;
            logic        bad;
            int          flen;
            int          viol;
            int          exp_v;
            int          exp_e;
            string       tag;
            cmd  = VEC[k][27];
            data = VEC[k][26:11];
            bad  = VEC[k][10];
            flen = int'(VEC[k][9:5]);
            viol = int'(VEC[k][4:0]);
            if (flen < 20 || flen > 28) begin
                exp_v = 0; exp_e = 0; tag = "R4";
            end else if (viol != 31) begin
                exp_v = 0; exp_e = 1; tag = "R8";
            end else if (bad) begin
                exp_v = 0; exp_e = 1; tag = "R7";
            end else begin
                exp_v = 1; exp_e = 0; tag = "R6";
            end
            v0 = n_valid;
            e0 = n_err;
            send(cmd, data, bad, flen, viol);
            check(n_valid - v0 == exp_v, $sformatf("%s valid count vec %0d", tag, k),
                  n_valid - v0, exp_v);
            check(n_err - e0 == exp_e, $sformatf("%s error count vec %0d", tag, k),
                  n_err - e0, exp_e);
            if (exp_v == 1) begin
                last_word = data;
                last_cmd  = cmd;
                check(word_o == last_word, $sformatf("R2 word vec %0d", k),
                      {16'h0, word_o}, {16'h0, last_word});
                check(cmd_o == last_cmd, $sformatf("R3 type vec %0d", k),
                      {31'h0, cmd_o}, {31'h0, last_cmd});
            end else begin
                check(word_o == last_word && cmd_o == last_cmd,
                      $sformatf("R9 held vec %0d", k),
                      {15'h0, cmd_o, word_o}, {15'h0, last_cmd, last_word});
            end
        end

        // R5: second header phase collapses before its midpoint
        v0 = n_valid;
        e0 = n_err;
        put(1'b1, 40);
        put(1'b0, 24);
        put(1'b1, 6);
        put(1'b0, 60);
        put(1'b1, 40);
        check(n_valid == v0 && n_err == e0, "R5 broken second phase",
              (n_valid - v0) + (n_err - e0), 0);
        check(word_o == last_word, "R9 held after R5 case",
              {16'h0, word_o}, {16'h0, last_word});

        // R3/R6: back-to-back command then data word, type follows header
        send(1'b1, 16'h0F0F, 1'b0, 24, 31);
        check(word_o == 16'h0F0F && cmd_o == 1'b1, "R3 command word",
              {15'h0, cmd_o, word_o}, {15'h0, 1'b1, 16'h0F0F});
        send(1'b0, 16'hF0F0, 1'b0, 22, 31);
        check(word_o == 16'hF0F0 && cmd_o == 1'b0, "R3 data word",
              {15'h0, cmd_o, word_o}, {15'h0, 1'b0, 16'hF0F0});

        check(n_both == 0, "R10 strobe overlap", n_both, 0);

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

endmodule